// File: doc/BRIEF.md
# Direct-Mode Data Address Generator

This block forms effective addresses for the three direct addressing forms of a word-oriented signal processor: data-page relative, stack relative and I/O-page relative. A request carries a mode select and a small offset field taken from the instruction. The block combines that offset with the matching page and pointer registers and presents either a 23-bit data-space address or a 16-bit I/O address, together with a strobe that names the target space. The address and strobe appear on registered outputs one clock after the request.

The page and pointer registers are loaded through a narrow write port. The data space is split into 128 pages of 64K words. In the data-page and stack forms, the page number comes straight from a page register and sits above a 16-bit in-page sum, so the sum never spills into the page. In the I/O form, the upper ten bits of the I/O page pointer are joined to a six-bit offset.

Top module: `dag_direct`

## Requirements
- R1: After a synchronous active-low reset, `data_stb` and `io_stb` are 0, `data_addr` and `io_addr` are 0, and all page and pointer registers read as 0.
- R2: A request with `req_mode` = 0 (data page) gives `data_stb` = 1 in the next cycle, with `data_addr[22:16]` = data page register and `data_addr[15:0]` = data pointer + offset. Writes to either page register keep only `wr_data[6:0]`.
- R3: A request with `req_mode` = 1 (stack) gives `data_stb` = 1 in the next cycle, with `data_addr[22:16]` = stack page register and `data_addr[15:0]` = stack pointer + offset.
- R4: A request with `req_mode` = 2 (I/O page) gives `io_stb` = 1 in the next cycle, with `io_addr[15:6]` = I/O page pointer bits [15:6] and `io_addr[5:0]` = `req_ofs[5:0]`. `req_ofs[6]` has no effect on this address.
- R5: The 16-bit in-page sum wraps modulo 65536 and never changes `data_addr[22:16]`.
- R6: The 7-bit offset is zero-extended before the add, so offset 0x7F adds 127.
- R7: A register write in the same cycle as a request does not affect that request's address. The next request uses the new value. Write selects are 0 data pointer, 1 data page, 2 stack pointer, 3 stack page, 4 I/O page pointer. Values 5 to 7 write nothing.
- R8: A cycle with `req_valid` = 0, or with `req_mode` = 3, gives both strobes 0 in the next cycle and leaves both addresses unchanged.
- R9: A data-space request leaves `io_addr` unchanged and an I/O request leaves `data_addr` unchanged. The two strobes are never 1 together.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| req_valid | input | 1 | Address request this cycle |
| req_mode | input | 2 | 0 data page, 1 stack, 2 I/O page, 3 reserved |
| req_ofs | input | 7 | Instruction offset field |
| wr_en | input | 1 | Register write enable |
| wr_sel | input | 3 | Register to write (see R7) |
| wr_data | input | 16 | Write value |
| data_addr | output | 23 | Registered data-space address |
| data_stb | output | 1 | Data-space address valid this cycle |
| io_addr | output | 16 | Registered I/O address |
| io_stb | output | 1 | I/O address valid this cycle |

## Verification
On every cycle, the assertions check the following. The strobes follow the previous cycle's mode, reserved and idle cycles hold both addresses, each request leaves the other space's address alone, and the page bits of a data address equal the page register sampled with the request, even when a write to that register lands in the same cycle. The wrap of the in-page sum, the zero extension of the offset, the ignored offset bit in I/O mode and the exact address values rest on the bench's scenarios. In those scenarios, a scoreboard computes every expected address from its own register model.

// File: rtl/dag_pkg.sv
package dag_pkg;
  localparam int PTR_W    = 16;
  localparam int PAGE_W   = 7;
  localparam int OFS_W    = 7;
  localparam int IO_AW    = 16;
  localparam int IO_PG_W  = 10;
  localparam int IO_OFS_W = IO_AW - IO_PG_W;
  localparam int DATA_AW  = PAGE_W + PTR_W;

  typedef enum logic [1:0] {
    AM_DPAGE = 2'd0,
    AM_STACK = 2'd1,
    AM_IOPG  = 2'd2,
    AM_RSVD  = 2'd3
  } am_mode_e;

  typedef enum logic [2:0] {
    RS_DP  = 3'd0,
    RS_DPG = 3'd1,
    RS_SP  = 3'd2,
    RS_SPG = 3'd3,
    RS_IOP = 3'd4
  } reg_sel_e;

  // page number on top, in-page sum wrapped to PTR_W bits below
  function automatic logic [DATA_AW-1:0] page_join(
    input logic [PAGE_W-1:0] page,
    input logic [PTR_W-1:0]  ptr,
    input logic [OFS_W-1:0]  ofs
  );
    logic [PTR_W-1:0] sum;
    sum = ptr + {{(PTR_W-OFS_W){1'b0}}, ofs};
    return {page, sum};
  endfunction

  function automatic logic [IO_AW-1:0] io_join(
    input logic [IO_PG_W-1:0]  pg,
    input logic [IO_OFS_W-1:0] ofs
  );
    return {pg, ofs};
  endfunction
endpackage

// File: rtl/dag_ptr_regs.sv
module dag_ptr_regs
  import dag_pkg::*;
#(
  parameter int P_PTR_W   = PTR_W,
  parameter int P_PAGE_W  = PAGE_W,
  parameter int P_IO_PG_W = IO_PG_W
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 wr_en,
  input  logic [2:0]           wr_sel,
  input  logic [P_PTR_W-1:0]   wr_data,
  output logic [P_PTR_W-1:0]   dp_q,
  output logic [P_PAGE_W-1:0]  dph_q,
  output logic [P_PTR_W-1:0]   sp_q,
  output logic [P_PAGE_W-1:0]  sph_q,
  output logic [P_IO_PG_W-1:0] iop_q
);
  localparam int IO_LSB = P_PTR_W - P_IO_PG_W;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      dp_q  <= '0;
      dph_q <= '0;
      sp_q  <= '0;
      sph_q <= '0;
      iop_q <= '0;
    end else if (wr_en) begin
      case (reg_sel_e'(wr_sel))
        RS_DP:   dp_q  <= wr_data;
        RS_DPG:  dph_q <= wr_data[P_PAGE_W-1:0];
        RS_SP:   sp_q  <= wr_data;
        RS_SPG:  sph_q <= wr_data[P_PAGE_W-1:0];
        RS_IOP:  iop_q <= wr_data[P_PTR_W-1:IO_LSB];
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/dag_ea_calc.sv
module dag_ea_calc
  import dag_pkg::*;
(
  input  logic                 req_valid,
  input  logic [1:0]           req_mode,
  input  logic [OFS_W-1:0]     req_ofs,
  input  logic [PTR_W-1:0]     dp_q,
  input  logic [PAGE_W-1:0]    dph_q,
  input  logic [PTR_W-1:0]     sp_q,
  input  logic [PAGE_W-1:0]    sph_q,
  input  logic [IO_PG_W-1:0]   iop_q,
  output logic                 hit_data,
  output logic                 hit_io,
  output logic [DATA_AW-1:0]   data_ea,
  output logic [IO_AW-1:0]     io_ea
);
  always_comb begin
    hit_data = 1'b0;
    hit_io   = 1'b0;
    data_ea  = page_join(dph_q, dp_q, req_ofs);
    io_ea    = io_join(iop_q, req_ofs[IO_OFS_W-1:0]);
    case (am_mode_e'(req_mode))
      AM_DPAGE: hit_data = req_valid;
      AM_STACK: begin
        hit_data = req_valid;
        data_ea  = page_join(sph_q, sp_q, req_ofs);
      end
      AM_IOPG:  hit_io = req_valid;
      default:  ;
    endcase
  end
endmodule

// File: rtl/dag_ea_hold.sv
module dag_ea_hold
  import dag_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               hit_data,
  input  logic               hit_io,
  input  logic [DATA_AW-1:0] data_ea,
  input  logic [IO_AW-1:0]   io_ea,
  output logic [DATA_AW-1:0] data_addr,
  output logic               data_stb,
  output logic [IO_AW-1:0]   io_addr,
  output logic               io_stb
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      data_addr <= '0;
      io_addr   <= '0;
      data_stb  <= 1'b0;
      io_stb    <= 1'b0;
    end else begin
      data_stb <= hit_data;
      io_stb   <= hit_io;
      if (hit_data) data_addr <= data_ea;
      if (hit_io)   io_addr   <= io_ea;
    end
  end
endmodule

// File: rtl/dag_direct.sv
module dag_direct
  import dag_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               req_valid,
  input  logic [1:0]         req_mode,
  input  logic [OFS_W-1:0]   req_ofs,
  input  logic               wr_en,
  input  logic [2:0]         wr_sel,
  input  logic [PTR_W-1:0]   wr_data,
  output logic [DATA_AW-1:0] data_addr,
  output logic               data_stb,
  output logic [IO_AW-1:0]   io_addr,
  output logic               io_stb
);
  logic [PTR_W-1:0]   dp_q;
  logic [PAGE_W-1:0]  dph_q;
  logic [PTR_W-1:0]   sp_q;
  logic [PAGE_W-1:0]  sph_q;
  logic [IO_PG_W-1:0] iop_q;
  logic               hit_data;
  logic               hit_io;
  logic [DATA_AW-1:0] data_ea;
  logic [IO_AW-1:0]   io_ea;

  dag_ptr_regs u_regs (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (wr_en),
    .wr_sel  (wr_sel),
    .wr_data (wr_data),
    .dp_q    (dp_q),
    .dph_q   (dph_q),
    .sp_q    (sp_q),
    .sph_q   (sph_q),
    .iop_q   (iop_q)
  );

  dag_ea_calc u_calc (
    .req_valid (req_valid),
    .req_mode  (req_mode),
    .req_ofs   (req_ofs),
    .dp_q      (dp_q),
    .dph_q     (dph_q),
    .sp_q      (sp_q),
    .sph_q     (sph_q),
    .iop_q     (iop_q),
    .hit_data  (hit_data),
    .hit_io    (hit_io),
    .data_ea   (data_ea),
    .io_ea     (io_ea)
  );

  dag_ea_hold u_hold (
    .clk       (clk),
    .rst_n     (rst_n),
    .hit_data  (hit_data),
    .hit_io    (hit_io),
    .data_ea   (data_ea),
    .io_ea     (io_ea),
    .data_addr (data_addr),
    .data_stb  (data_stb),
    .io_addr   (io_addr),
    .io_stb    (io_stb)
  );
endmodule

// File: rtl/dag_direct_chk.sv
module dag_direct_chk
  import dag_pkg::*;
(
  input logic               clk,
  input logic               rst_n,
  input logic               req_valid,
  input logic [1:0]         req_mode,
  input logic               wr_en,
  input logic [2:0]         wr_sel,
  input logic [PAGE_W-1:0]  dph_q,
  input logic [PAGE_W-1:0]  sph_q,
  input logic [DATA_AW-1:0] data_addr,
  input logic               data_stb,
  input logic [IO_AW-1:0]   io_addr,
  input logic               io_stb
);
  logic req_dat, req_stk, req_io, req_none;
  assign req_dat  = req_valid && (req_mode == AM_DPAGE);
  assign req_stk  = req_valid && (req_mode == AM_STACK);
  assign req_io   = req_valid && (req_mode == AM_IOPG);
  assign req_none = !req_valid || (req_mode == AM_RSVD);

  p_dstb_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (req_dat || req_stk) |=> (data_stb && !io_stb));

  p_istb_r4: assert property (@(posedge clk) disable iff (!rst_n)
    req_io |=> (io_stb && !data_stb));

  p_dpage_r5: assert property (@(posedge clk) disable iff (!rst_n)
    req_dat |=> (data_addr[DATA_AW-1:PTR_W] == $past(dph_q)));

  p_spage_r3: assert property (@(posedge clk) disable iff (!rst_n)
    req_stk |=> (data_addr[DATA_AW-1:PTR_W] == $past(sph_q)));

  // R7: same-cycle page write is not seen by the request
  p_old_page_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (req_dat && wr_en && wr_sel == RS_DPG) |=>
      (data_addr[DATA_AW-1:PTR_W] == $past(dph_q)));

  p_idle_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    req_none |=> (!data_stb && !io_stb && $stable(data_addr) && $stable(io_addr)));

  p_io_keep_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (req_dat || req_stk) |=> $stable(io_addr));

  p_data_keep_r9: assert property (@(posedge clk) disable iff (!rst_n)
    req_io |=> $stable(data_addr));

  p_excl_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !(data_stb && io_stb));
endmodule

bind dag_direct dag_direct_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .req_valid (req_valid),
  .req_mode  (req_mode),
  .wr_en     (wr_en),
  .wr_sel    (wr_sel),
  .dph_q     (dph_q),
  .sph_q     (sph_q),
  .data_addr (data_addr),
  .data_stb  (data_stb),
  .io_addr   (io_addr),
  .io_stb    (io_stb)
);

// File: tb/tb_dag_direct.sv
module tb_dag_direct;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic [1:0]  req_mode = 2'd0;
  logic [6:0]  req_ofs = 7'd0;
  logic        wr_en = 1'b0;
  logic [2:0]  wr_sel = 3'd0;
  logic [15:0] wr_data = 16'd0;
  logic [22:0] data_addr;
  logic        data_stb;
  logic [15:0] io_addr;
  logic        io_stb;

  always #2 clk = ~clk;

  dag_direct dut (.*);

  typedef struct {
    logic        dstb;
    logic        istb;
    logic [22:0] da;
    logic [15:0] ia;
    string       tag;
  } exp_t;

  exp_t q[$];
  int   n_vec = 0;
  int   n_bad = 0;
  bit   done = 0;

  // bench register model
  int m_dp = 0, m_dpg = 0, m_sp = 0, m_spg = 0, m_iop = 0;
  int e_da = 0, e_ia = 0;

  task automatic step(input bit rq, input int md, input int of,
                      input bit we, input int ws, input int wd, input string tag);
    exp_t e;
    @(negedge clk);
    req_valid = rq; req_mode = md[1:0]; req_ofs = of[6:0];
    wr_en = we; wr_sel = ws[2:0]; wr_data = wd[15:0];
    e.dstb = 0; e.istb = 0;
    if (rq && md == 0) begin
      e.dstb = 1; e_da = m_dpg * 65536 + ((m_dp + of) % 65536);
    end else if (rq && md == 1) begin
      e.dstb = 1; e_da = m_spg * 65536 + ((m_sp + of) % 65536);
    end else if (rq && md == 2) begin
      e.istb = 1; e_ia = (m_iop / 64) * 64 + (of % 64);
    end
    e.da = e_da[22:0]; e.ia = e_ia[15:0]; e.tag = tag;
    q.push_back(e);
    if (we) begin
      case (ws)
        0: m_dp  = wd % 65536;
        1: m_dpg = wd % 128;
        2: m_sp  = wd % 65536;
        3: m_spg = wd % 128;
        4: m_iop = wd % 65536;
        default: ;
      endcase
    end
  endtask

  task automatic wr(input int ws, input int wd, input string tag);
    step(0, 0, 0, 1, ws, wd, tag);
  endtask

  task automatic rq(input int md, input int of, input string tag);
    step(1, md, of, 0, 0, 0, tag);
  endtask

  // monitor
  always @(posedge clk) begin
    #1;
    if (rst_n && q.size() > 0) begin
      exp_t e;
      e = q.pop_front();
      n_vec++;
      if (data_stb !== e.dstb || io_stb !== e.istb ||
          data_addr !== e.da || io_addr !== e.ia) begin
        n_bad++;
        $display("FAIL %s: got dstb=%0b istb=%0b da=%h ia=%h exp dstb=%0b istb=%0b da=%h ia=%h",
                 e.tag, data_stb, io_stb, data_addr, io_addr, e.dstb, e.istb, e.da, e.ia);
      end
    end
  end

  initial begin
    #(4 * 20000);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: got hung run exp completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(posedge clk); #1;
    n_vec++;
    if (data_stb !== 0 || io_stb !== 0 || data_addr !== 0 || io_addr !== 0) begin
      n_bad++;
      $display("FAIL R1: got dstb=%0b istb=%0b da=%h ia=%h exp all zero",
               data_stb, io_stb, data_addr, io_addr);
    end
    rq(0, 5, "R1 regs zero data");
    rq(1, 9, "R1 regs zero stack");
    rq(2, 3, "R1 regs zero io");
    wr(0, 'h1234, "R7 write dp");
    wr(1, 'hFF85, "R2 dpage low bits");
    wr(2, 'hFFF0, "R7 write sp");
    wr(3, 'h007F, "R7 write spage");
    wr(4, 'hABCD, "R7 write iop");
    rq(0, 'h10, "R2 data page");
    rq(0, 'h7F, "R6 zero extend");
    rq(1, 'h05, "R3 stack");
    rq(1, 'h20, "R5 stack wrap");
    rq(2, 'h7F, "R4 io bit6 ignored");
    rq(2, 'h3F, "R4 io");
    rq(0, 0, "R9 io holds");
    step(0, 2, 'h11, 0, 0, 0, "R8 idle");
    step(1, 3, 'h22, 0, 0, 0, "R8 reserved");
    wr(0, 'hFFFF, "R7 dp near top");
    rq(0, 'h7F, "R5 data wrap");
    step(1, 0, 1, 1, 1, 'h0033, "R7 same-cycle page write");
    rq(0, 1, "R7 next sees new page");
    step(1, 1, 2, 1, 2, 'h0100, "R7 same-cycle sp write");
    rq(1, 2, "R7 next sees new sp");
    wr(7, 'h5555, "R7 sel7 ignored");
    wr(5, 'h0000, "R7 sel5 ignored");
    rq(0, 0, "R7 no write on sel5/7");
    rq(1, 0, "R7 no write on sel5/7 stack");
    rq(2, 0, "R9 data holds");
    for (int i = 0; i < 24; i++) begin
      step(1, i % 4, (i * 37) % 128, (i % 3) == 0, i % 6, (i * 40503) % 65536, "R2 R3 R4 mix");
    end
    step(0, 0, 0, 0, 0, 0, "R8 final idle");
    @(negedge clk);
    @(negedge clk);
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule